// File: doc/BRIEF.md
# Battery cell protection mode controller

This block decides, from already-digitised comparator flags, which switches of a single-cell battery protector are closed. It holds a normal mode and one mode for each fault: over-charge, a short circuit found while over-charged, discharge over-current, charge over-current, an under-voltage standby, and an under-voltage state in which the cell is charging. It drives the charge-switch enable, the discharge-switch enable, the sense-pin pull-down and pull-up enables, and the bias enable.

A fault is accepted only after its flag has been held for a programmable number of slow `tick_i` pulses. A separate counter qualifies each fault and each timed release, and it clears whenever its flag drops, so a glitch shorter than the delay changes nothing. Each fault has its own recovery rule. A short circuit found while over-charged returns to over-charge, not to normal. Under-voltage first shuts the bias down. The block wakes when a charger is attached or when the cell climbs past the auto-wake level, and it returns to normal once the release level has been held.

Top module: `bprot_ctrl`

## Requirements
- R1: After reset the block is in normal mode with all counters clear: chg_en_o=1, dchg_en_o=1, pd_en_o=0, pu_en_o=0, bias_en_o=1.
- R2: A qualifying condition advances its counter once per cycle with tick_i=1, only while the condition holds. It fires when the counter equals its delay and the condition is still true, and the state changes at the next clock edge. If the condition drops, the counter clears. With tick_i held high, a flag held for exactly DLY cycles never changes the state.
- R3: In normal mode, cell_ov_i held for OV_DLY ticks enters over-charge: chg_en_o=0 and dchg_en_o=1.
- R4: Over-charge returns to normal (chg_en_o=1) only when charger_i=0 and cell_ovr_i have been held together for OVR_DLY ticks. While charger_i=1, the block stays in over-charge.
- R5: In over-charge, sns_sc_i held for SC_DLY ticks gives dchg_en_o=0 and pd_en_o=1. One clock after load_i=0 and sns_sc_i=0, the block returns to over-charge (chg_en_o=0, dchg_en_o=1, pd_en_o=0).
- R6: In normal mode, sns_oc_i held for OC_DLY ticks enters discharge over-current (dchg_en_o=0, pd_en_o=1). One clock after load_i=0 and sns_oc_i=0, the block is back in normal.
- R7: In normal mode, cell_uv_i held for UV_DLY ticks enters standby: dchg_en_o=0, pu_en_o=1, bias_en_o=0, chg_en_o=1.
- R8: One clock after charger_i=1 or cell_wake_i=1 in standby, bias_en_o=1 and pu_en_o=0.
- R9: After wake, dchg_en_o follows sns_chg_i. When cell_uvr_i has been held for UVR_DLY ticks, the block returns to normal.
- R10: In normal mode, chg_oc_i held for OCC_DLY ticks gives chg_en_o=0 with dchg_en_o=1. The block returns to normal one clock after charger_i=0. chg_oc_i has no effect in either under-voltage state.
- R11: When several faults qualify in the same cycle, short circuit and discharge over-current win over under-voltage, under-voltage wins over over-charge, and over-charge wins over charge over-current. A short circuit in normal mode enters the discharge over-current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow delay tick enable |
| cell_ov_i | input | 1 | Cell at or above over-charge threshold |
| cell_ovr_i | input | 1 | Cell below over-charge release threshold |
| cell_uv_i | input | 1 | Cell below under-voltage threshold |
| cell_uvr_i | input | 1 | Cell above under-voltage release threshold |
| cell_wake_i | input | 1 | Cell above auto-wake threshold |
| sns_oc_i | input | 1 | Sense at or above discharge over-current level |
| sns_sc_i | input | 1 | Sense above short-circuit level |
| sns_chg_i | input | 1 | Sense below charger-detect level |
| chg_oc_i | input | 1 | Charge over-current flag |
| charger_i | input | 1 | Charger attached |
| load_i | input | 1 | Load attached |
| chg_en_o | output | 1 | Charge switch enable |
| dchg_en_o | output | 1 | Discharge switch enable |
| pd_en_o | output | 1 | Sense-pin pull-down enable |
| pu_en_o | output | 1 | Sense-pin pull-up enable |
| bias_en_o | output | 1 | Bias enable (0 = standby) |

## Verification
The bench uses delays of 2 and 3 ticks: OV_DLY, OC_DLY and UV_DLY are 3, and OVR_DLY, SC_DLY, UVR_DLY and OCC_DLY are 2. These short delays let a random flag sequence reach every mode within a few cycles. They also bring the exact boundary (held DLY cycles against DLY+1) within reach of directed checks. The random phase randomises tick_i, so the hold-without-tick path of each counter is exercised. Equal delays for over-current, under-voltage and over-charge make the priority order observable when all three flags rise together.

// File: rtl/bprot_pkg.sv
package bprot_pkg;
  typedef enum logic [2:0] {
    ST_NORM, ST_OVC, ST_OVC_SC, ST_DOC, ST_UV_STBY, ST_UV_ACT, ST_COC
  } mode_e;

  localparam int unsigned N_TMR = 7;
  localparam int unsigned T_OV  = 0;
  localparam int unsigned T_OVR = 1;
  localparam int unsigned T_SC  = 2;
  localparam int unsigned T_OC  = 3;
  localparam int unsigned T_UV  = 4;
  localparam int unsigned T_UVR = 5;
  localparam int unsigned T_OCC = 6;
endpackage

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int unsigned DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned W = (DLY < 1) ? 1 : $clog2(DLY + 1);
  localparam logic [W-1:0] LIM = W'(DLY);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!cond_i)              cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = cond_i && (cnt_q == LIM);

  a_r2_clear_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> cnt_q == '0);
  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && !tick_i) |=> $stable(cnt_q));
  a_r2_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
endmodule

// File: rtl/bprot_fsm.sv
module bprot_fsm
  import bprot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_TMR-1:0] done_i,
  input  logic             sns_oc_i,
  input  logic             sns_sc_i,
  input  logic             cell_wake_i,
  input  logic             charger_i,
  input  logic             load_i,
  output mode_e            mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      ST_NORM: begin
        // priority: short / over-current, under-voltage, over-charge, charge OC
        if (done_i[T_SC] || done_i[T_OC]) mode_d = ST_DOC;
        else if (done_i[T_UV])            mode_d = ST_UV_STBY;
        else if (done_i[T_OV])            mode_d = ST_OVC;
        else if (done_i[T_OCC])           mode_d = ST_COC;
      end
      ST_OVC: begin
        if (done_i[T_SC])       mode_d = ST_OVC_SC;
        else if (done_i[T_OVR]) mode_d = ST_NORM;
      end
      ST_OVC_SC:  if (!load_i && !sns_sc_i) mode_d = ST_OVC;
      ST_DOC:     if (!load_i && !sns_oc_i) mode_d = ST_NORM;
      ST_UV_STBY: if (charger_i || cell_wake_i) mode_d = ST_UV_ACT;
      ST_UV_ACT:  if (done_i[T_UVR]) mode_d = ST_NORM;
      ST_COC:     if (!charger_i) mode_d = ST_NORM;
      default:    mode_d = ST_NORM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= ST_NORM;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  a_r5_sc_back_to_ovc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ST_OVC_SC && !load_i && !sns_sc_i) |=> mode_q == ST_OVC);
  a_r4_charger_blocks_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ST_OVC && charger_i) |=> mode_q != ST_NORM);
  a_r8_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ST_UV_STBY && (charger_i || cell_wake_i)) |=> mode_q == ST_UV_ACT);
  a_r10_no_occ_in_uv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ST_UV_ACT) |=> (mode_q == ST_UV_ACT || mode_q == ST_NORM));
  a_r6_doc_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ST_DOC && !load_i && !sns_oc_i) |=> mode_q == ST_NORM);
endmodule

// File: rtl/bprot_out.sv
module bprot_out
  import bprot_pkg::*;
(
  input  mode_e mode_i,
  input  logic  sns_chg_i,
  output logic  chg_en_o,
  output logic  dchg_en_o,
  output logic  pd_en_o,
  output logic  pu_en_o,
  output logic  bias_en_o
);
  always_comb begin
    chg_en_o  = 1'b1;
    dchg_en_o = 1'b1;
    pd_en_o   = 1'b0;
    pu_en_o   = 1'b0;
    bias_en_o = 1'b1;
    unique case (mode_i)
      ST_OVC:     chg_en_o = 1'b0;
      ST_OVC_SC:  begin chg_en_o = 1'b0; dchg_en_o = 1'b0; pd_en_o = 1'b1; end
      ST_DOC:     begin dchg_en_o = 1'b0; pd_en_o = 1'b1; end
      ST_UV_STBY: begin dchg_en_o = 1'b0; pu_en_o = 1'b1; bias_en_o = 1'b0; end
      ST_UV_ACT:  dchg_en_o = sns_chg_i; // cut dissipation while charging
      ST_COC:     chg_en_o = 1'b0;
      default:    ;
    endcase
  end
endmodule

// File: rtl/bprot_ctrl.sv
module bprot_ctrl
  import bprot_pkg::*;
#(
  parameter int unsigned OV_DLY  = 16,
  parameter int unsigned OVR_DLY = 16,
  parameter int unsigned SC_DLY  = 2,
  parameter int unsigned OC_DLY  = 8,
  parameter int unsigned UV_DLY  = 16,
  parameter int unsigned UVR_DLY = 16,
  parameter int unsigned OCC_DLY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cell_ov_i,
  input  logic cell_ovr_i,
  input  logic cell_uv_i,
  input  logic cell_uvr_i,
  input  logic cell_wake_i,
  input  logic sns_oc_i,
  input  logic sns_sc_i,
  input  logic sns_chg_i,
  input  logic chg_oc_i,
  input  logic charger_i,
  input  logic load_i,
  output logic chg_en_o,
  output logic dchg_en_o,
  output logic pd_en_o,
  output logic pu_en_o,
  output logic bias_en_o
);
  mode_e            mode;
  logic [N_TMR-1:0] cond, done;

  // each counter runs only in the mode where its flag matters
  always_comb begin
    cond        = '0;
    cond[T_OV]  = (mode == ST_NORM) && cell_ov_i;
    cond[T_OVR] = (mode == ST_OVC) && cell_ovr_i && !charger_i;
    cond[T_SC]  = (mode == ST_NORM || mode == ST_OVC) && sns_sc_i;
    cond[T_OC]  = (mode == ST_NORM) && sns_oc_i;
    cond[T_UV]  = (mode == ST_NORM) && cell_uv_i;
    cond[T_UVR] = (mode == ST_UV_ACT) && cell_uvr_i;
    cond[T_OCC] = (mode == ST_NORM) && chg_oc_i;
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam int unsigned D =
      (i == T_OV)  ? OV_DLY  : (i == T_OVR) ? OVR_DLY :
      (i == T_SC)  ? SC_DLY  : (i == T_OC)  ? OC_DLY  :
      (i == T_UV)  ? UV_DLY  : (i == T_UVR) ? UVR_DLY : OCC_DLY;
    qual_timer #(.DLY(D)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .cond_i(cond[i]),
      .done_o(done[i])
    );
  end

  bprot_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .sns_oc_i   (sns_oc_i),
    .sns_sc_i   (sns_sc_i),
    .cell_wake_i(cell_wake_i),
    .charger_i  (charger_i),
    .load_i     (load_i),
    .mode_o     (mode)
  );

  bprot_out u_out (
    .mode_i   (mode),
    .sns_chg_i(sns_chg_i),
    .chg_en_o (chg_en_o),
    .dchg_en_o(dchg_en_o),
    .pd_en_o  (pd_en_o),
    .pu_en_o  (pu_en_o),
    .bias_en_o(bias_en_o)
  );

  a_r7_standby_switches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bias_en_o |-> (!dchg_en_o && pu_en_o));
  a_r5_pd_excl_dchg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_en_o |-> !dchg_en_o);
  a_r11_sc_over_uv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == ST_NORM && done[T_SC] && done[T_UV]) |=> pd_en_o);
endmodule

// File: tb/bprot_ctrl_tb.sv
module bprot_ctrl_tb;
  localparam int D[7] = '{3, 2, 2, 3, 3, 2, 2}; // ov ovr sc oc uv uvr occ
  localparam logic [10:0] IDLE = 11'h01A;        // ovr, uvr, wake high

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [10:0] iv = IDLE; // 0 ov 1 ovr 2 uv 3 uvr 4 wake 5 oc 6 sc 7 chgdet 8 occ 9 charger 10 load
  logic chg, dchg, pd, pu, bias;
  int n_vec = 0, n_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  bprot_ctrl #(.OV_DLY(D[0]), .OVR_DLY(D[1]), .SC_DLY(D[2]), .OC_DLY(D[3]),
               .UV_DLY(D[4]), .UVR_DLY(D[5]), .OCC_DLY(D[6])) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cell_ov_i(iv[0]), .cell_ovr_i(iv[1]), .cell_uv_i(iv[2]), .cell_uvr_i(iv[3]),
    .cell_wake_i(iv[4]), .sns_oc_i(iv[5]), .sns_sc_i(iv[6]), .sns_chg_i(iv[7]),
    .chg_oc_i(iv[8]), .charger_i(iv[9]), .load_i(iv[10]),
    .chg_en_o(chg), .dchg_en_o(dchg), .pd_en_o(pd), .pu_en_o(pu), .bias_en_o(bias));

  // reference model: 0 norm 1 ovc 2 ovc_sc 3 doc 4 stby 5 uv_act 6 coc
  int ms;
  int mc[7];
  logic [6:0] mcond, mdone;

  always_comb begin
    mcond[0] = ms == 0 && iv[0];
    mcond[1] = ms == 1 && iv[1] && !iv[9];
    mcond[2] = (ms == 0 || ms == 1) && iv[6];
    mcond[3] = ms == 0 && iv[5];
    mcond[4] = ms == 0 && iv[2];
    mcond[5] = ms == 5 && iv[3];
    mcond[6] = ms == 0 && iv[8];
    for (int i = 0; i < 7; i++) mdone[i] = mcond[i] && mc[i] == D[i];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= 0;
      for (int i = 0; i < 7; i++) mc[i] <= 0;
    end else begin
      for (int i = 0; i < 7; i++)
        if (!mcond[i]) mc[i] <= 0;
        else if (tick && mc[i] != D[i]) mc[i] <= mc[i] + 1;
      case (ms)
        0: if (mdone[2] || mdone[3]) ms <= 3; else if (mdone[4]) ms <= 4;
           else if (mdone[0]) ms <= 1; else if (mdone[6]) ms <= 6;
        1: if (mdone[2]) ms <= 2; else if (mdone[1]) ms <= 0;
        2: if (!iv[10] && !iv[6]) ms <= 1;
        3: if (!iv[10] && !iv[5]) ms <= 0;
        4: if (iv[9] || iv[4]) ms <= 5;
        5: if (mdone[5]) ms <= 0;
        6: if (!iv[9]) ms <= 0;
        default: ms <= 0;
      endcase
    end
  end

  function automatic logic [4:0] exp_out(int s, logic cd); // chg dchg pd pu bias
    case (s)
      1: return 5'b01001;
      2: return 5'b00101;
      3: return 5'b10101;
      4: return 5'b10010;
      5: return {1'b1, cd, 3'b001};
      6: return 5'b01001;
      default: return 5'b11001;
    endcase
  endfunction

  task automatic cmp_model();
    logic [4:0] a, e;
    string tg[5] = '{"R3 chg", "R6 dchg", "R5 pd", "R7 pu", "R8 bias"};
    a = {chg, dchg, pd, pu, bias};
    e = exp_out(ms, iv[7]);
    n_vec++;
    for (int k = 0; k < 5; k++)
      if (a[4-k] !== e[4-k]) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b (state %0d)", tg[k], a[4-k], e[4-k], ms);
      end
  endtask

  task automatic chk(logic [4:0] e, string tag);
    n_vec++;
    if ({chg, dchg, pd, pu, bias} !== e) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, {chg, dchg, pd, pu, bias}, e);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(negedge clk); cmp_model(); end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(5'b11001, "R1 reset");
    rst_n = 1'b1;
    step(1);
    chk(5'b11001, "R1 after release");
    // R2: hold exactly OV_DLY cycles -> no change
    iv[0] = 1; step(3); iv[0] = 0; step(2);
    chk(5'b11001, "R2 short glitch");
    // R3
    iv[0] = 1; step(5); chk(5'b01001, "R3 over-charge");
    iv[0] = 0; iv[1] = 0; step(2);
    // R4: charger blocks release
    iv[1] = 1; iv[9] = 1; step(5); chk(5'b01001, "R4 charger blocks");
    iv[9] = 0; step(4); chk(5'b11001, "R4 release");
    // R5
    iv[0] = 1; iv[1] = 0; step(5); iv[0] = 0;
    iv[6] = 1; iv[10] = 1; step(4); chk(5'b00101, "R5 short in ovc");
    iv[6] = 0; step(3); chk(5'b00101, "R5 load holds");
    iv[10] = 0; step(2); chk(5'b01001, "R5 back to ovc");
    iv[1] = 1; step(4); chk(5'b11001, "R4 normal again");
    // R6
    iv[5] = 1; iv[10] = 1; step(5); chk(5'b10101, "R6 doc");
    iv[5] = 0; step(2); chk(5'b10101, "R6 load holds");
    iv[10] = 0; step(2); chk(5'b11001, "R6 exit");
    // R7 / R8 / R9 / R10 suppression
    iv[2] = 1; iv[3] = 0; iv[4] = 0; step(5); chk(5'b10010, "R7 standby");
    iv[8] = 1; step(2); chk(5'b10010, "R7 stays");
    iv[9] = 1; step(2); chk(5'b10001, "R8 charger wake");
    iv[7] = 1; step(1); chk(5'b11001, "R9 dchg on chgdet");
    iv[7] = 0; step(1); chk(5'b10001, "R9 dchg off");
    step(3); chk(5'b10001, "R10 occ ignored in uv");
    iv[8] = 0; iv[2] = 0; iv[3] = 1; step(4); chk(5'b11001, "R9 release");
    iv[9] = 0; step(1);
    iv[2] = 1; iv[3] = 0; step(5); iv[4] = 1; step(2);
    chk(5'b10001, "R8 auto wake");
    iv[2] = 0; iv[3] = 1; step(4); chk(5'b11001, "R9 release 2");
    // R10
    iv[9] = 1; iv[8] = 1; step(4); chk(5'b01001, "R10 charge oc");
    iv[8] = 0; step(2); chk(5'b01001, "R10 charger holds");
    iv[9] = 0; step(2); chk(5'b11001, "R10 exit");
    // R11: over-current, under-voltage, over-charge together
    iv[5] = 1; iv[2] = 1; iv[0] = 1; iv[3] = 0; iv[10] = 1; step(5);
    chk(5'b10101, "R11 priority");
    iv = IDLE; step(2); chk(5'b11001, "R11 recover");
    // R11: short circuit in normal beats under-voltage
    iv[6] = 1; iv[2] = 1; iv[3] = 0; iv[10] = 1; step(5);
    chk(5'b10101, "R11 short first");
    iv = IDLE; step(2);
    // random phase
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk); cmp_model();
      tick = ($urandom % 3) != 0;
      if (($urandom % 4) == 0) iv[$urandom % 11] ^= 1'b1;
      if (($urandom % 64) == 0) iv = IDLE;
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done_flag) begin
      done_flag = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule